// File: doc/BRIEF.md
# Delayed-Sample Transient Error Sensor

This block guards a set of pipeline stage registers against transient upsets. Each stage keeps its normal functional register and adds a shadow register. The shadow register samples the same combinational word at a later instant. In this single-clock model, the later instant is a sampling strobe that arrives on a later clock edge than the functional capture. After every shadow capture, the two copies of each stage are compared bit by bit. A difference in any bit of any stage means one of the two samples was hit by a glitch or an upset.

The sensor does not try to correct the value. It raises a report one clock after the shadow sampling edge. The report is a sticky flag plus the number of the lowest stage that disagreed, and both stay up until the local agent acknowledges them. The functional outputs pass through untouched, so the only cost to the protected path is the extra register load on each stage's input.

Top module: `shadow_err_sensor`

## Requirements
- R1: Stage `s` of `data_o` (bits `s*WIDTH` and up) loads the same bits of `data_i` at a clock edge where `cap_i` is 1 and holds its value otherwise. `shadow_stb_i`, `ack_i` and the error state never change `data_o`.
- R2: The shadow copy of every stage loads `data_i` at a clock edge where `shadow_stb_i` is 1. A comparison between the functional and shadow copies counts only in the clock cycle that directly follows such an edge.
- R3: In a counted comparison, any difference in one or more bits of any stage is a mismatch. Identical copies in every stage give no mismatch.
- R4: A mismatch from the shadow edge at edge k sets `err_o` at edge k+1. `err_o` does not change at edge k itself.
- R5: A mismatch is reported whichever of the two samples carries the wrong value: a disturbed word at the functional capture or a disturbed word at the shadow capture.
- R6: Once set, `err_o` stays 1 at every edge where `ack_i` is 0.
- R7: At an edge with `ack_i` = 1 and no counted mismatch, `err_o` and `err_stage_o` return to 0. If a counted mismatch meets `ack_i` at the same edge, the new report wins: `err_o` stays 1 with the new stage index.
- R8: `err_stage_o` carries the lowest-numbered mismatching stage, taken when the flag is set. It is frozen while the flag stays set, even if later mismatches occur. It is 0 whenever `err_o` is 0.
- R9: While `rst_ni` is 0, `data_o`, the shadow copies, `err_o` and `err_stage_o` are all 0.
- R10: When `cap_i` and `shadow_stb_i` are both 1 at the same edge, both copies take the same word and no mismatch follows.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | N_STAGES*WIDTH | Combinational outputs of all stages, with stage 0 in the low bits |
| cap_i | input | 1 | Functional register load |
| shadow_stb_i | input | 1 | Delayed sampling strobe that loads the shadow registers |
| ack_i | input | 1 | Agent acknowledge, one pulse clears the report |
| data_o | output | N_STAGES*WIDTH | Functional register contents |
| err_o | output | 1 | Sticky error report flag |
| err_stage_o | output | max(1,clog2(N_STAGES)) | Lowest mismatching stage |

## Verification
The assertions check these rules on every cycle:
- the functional data loads and holds as R1 states;
- a report rises only one cycle after a counted mismatch;
- the flag persists until an acknowledge;
- an acknowledge with no fresh mismatch clears the flag;
- a newly reported index names a mismatching stage with none below it.

Some behaviours can only be shown by the bench's scenarios, because they depend on which word was disturbed and when:
- glitches placed at the functional instant or at the shadow instant, in one stage or several;
- an acknowledge landing on the same edge as a new mismatch;
- freezing of the index while later mismatches arrive;
- the same-edge capture of both copies.

// File: rtl/shadow_sense_pkg.sv
package shadow_sense_pkg;
  function automatic int unsigned idx_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sense_stage.sv
module sense_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             shd_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             diff_o
);
  logic [WIDTH-1:0] func_q;
  logic [WIDTH-1:0] shad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    func_q <= '0;
    else if (cap_i) func_q <= d_i;
  end

  // delayed sample of the same combinational word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    shad_q <= '0;
    else if (shd_i) shad_q <= d_i;
  end

  assign q_o    = func_q;
  assign diff_o = |(func_q ^ shad_q);
endmodule

// File: rtl/sense_prio.sv
module sense_prio #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned IW    = 2
) (
  input  logic [N_REQ-1:0] req_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/sense_report.sv
module sense_report #(
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [IW-1:0] hit_idx_i,
  input  logic          ack_i,
  output logic          err_o,
  output logic [IW-1:0] idx_o
);
  logic          err_q;
  logic [IW-1:0] idx_q;
  logic          take;

  // new report only when idle or being acknowledged
  assign take = hit_i && (!err_q || ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      idx_q <= '0;
    end else if (take) begin
      err_q <= 1'b1;
      idx_q <= hit_idx_i;
    end else if (ack_i) begin
      err_q <= 1'b0;
      idx_q <= '0;
    end
  end

  assign err_o = err_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/shadow_err_sensor.sv
module shadow_err_sensor
  import shadow_sense_pkg::*;
#(
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned WIDTH    = 8,
  localparam int unsigned NW      = N_STAGES * WIDTH,
  localparam int unsigned IDX_W   = idx_bits(N_STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NW-1:0]    data_i,
  input  logic             cap_i,
  input  logic             shadow_stb_i,
  input  logic             ack_i,
  output logic [NW-1:0]    data_o,
  output logic             err_o,
  output logic [IDX_W-1:0] err_stage_o
);
  logic                chk_q;
  logic [N_STAGES-1:0] stage_diff;
  logic [N_STAGES-1:0] mis_vec;
  logic                mis_any;
  logic [IDX_W-1:0]    mis_idx;

  // comparison window: cycle after shadow capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_q <= 1'b0;
    else         chk_q <= shadow_stb_i;
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    sense_stage #(.WIDTH(WIDTH)) i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (cap_i),
      .shd_i  (shadow_stb_i),
      .d_i    (data_i[s*WIDTH +: WIDTH]),
      .q_o    (data_o[s*WIDTH +: WIDTH]),
      .diff_o (stage_diff[s])
    );
  end

  assign mis_vec = stage_diff & {N_STAGES{chk_q}};

  sense_prio #(.N_REQ(N_STAGES), .IW(IDX_W)) i_prio (
    .req_i (mis_vec),
    .any_o (mis_any),
    .idx_o (mis_idx)
  );

  sense_report #(.IW(IDX_W)) i_report (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (mis_any),
    .hit_idx_i (mis_idx),
    .ack_i     (ack_i),
    .err_o     (err_o),
    .idx_o     (err_stage_o)
  );
endmodule

// File: rtl/shadow_err_sensor_chk.sv
module shadow_err_sensor_chk #(
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned IW       = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_STAGES*WIDTH-1:0] data_i,
  input logic                      cap_i,
  input logic                      ack_i,
  input logic [N_STAGES*WIDTH-1:0] data_o,
  input logic                      err_o,
  input logic [IW-1:0]             err_stage_o,
  input logic [N_STAGES-1:0]       mis_vec
);
  // R1
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> data_o == $past(data_i));

  // R1
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(data_o));

  // R4
  late_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(|mis_vec));

  // R6
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !ack_i |=> err_o && $stable(err_stage_o));

  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !(|mis_vec) |=> !err_o);

  // R8
  idx_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ((($past(mis_vec) >> err_stage_o) & N_STAGES'(1)) != '0));

  // R8
  idx_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |->
      (($past(mis_vec) & ((N_STAGES'(1) << err_stage_o) - N_STAGES'(1))) == '0));

  // R8
  idx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> err_stage_o == '0);
endmodule

bind shadow_err_sensor shadow_err_sensor_chk #(
  .N_STAGES (N_STAGES),
  .WIDTH    (WIDTH),
  .IW       (IDX_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_i      (data_i),
  .cap_i       (cap_i),
  .ack_i       (ack_i),
  .data_o      (data_o),
  .err_o       (err_o),
  .err_stage_o (err_stage_o),
  .mis_vec     (mis_vec)
);

// File: tb/test_shadow_err_sensor.sv
module test_shadow_err_sensor;
  localparam int unsigned NS = 4;
  localparam int unsigned W  = 8;
  localparam int unsigned NW = NS * W;
  localparam int unsigned IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] d = '0;
  logic          cap = 1'b0, shd = 1'b0, ack = 1'b0;
  logic [NW-1:0] q;
  logic          err;
  logic [IW-1:0] idx;

  int n_chk = 0, n_fail = 0;

  logic [NW-1:0] m_func = '0, m_shad = '0;
  logic          m_chk = 1'b0, m_err = 1'b0;
  logic [IW-1:0] m_idx = '0;

  always #5 clk = ~clk;

  shadow_err_sensor #(.N_STAGES(NS), .WIDTH(W)) i_shadow_err_sensor (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d), .cap_i(cap), .shadow_stb_i(shd),
    .ack_i(ack), .data_o(q), .err_o(err), .err_stage_o(idx)
  );

  function automatic logic [NS-1:0] diff_vec(logic [NW-1:0] a, logic [NW-1:0] b);
    logic [NS-1:0] v;
    for (int s = 0; s < NS; s++) v[s] = (a[s*W +: W] != b[s*W +: W]);
    return v;
  endfunction

  function automatic logic [IW-1:0] low_idx(logic [NS-1:0] v);
    for (int s = 0; s < NS; s++) if (v[s]) return IW'(s);
    return '0;
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "data_o", q, m_func);
    check(tag, "err_o", err, m_err);
    check(tag, "err_stage_o", idx, m_idx);
  endtask

  // drive at negedge, model the edge, sample at next negedge
  task automatic step(logic c, logic s, logic a, logic [NW-1:0] dv, string tag);
    logic [NS-1:0] mv;
    cap = c; shd = s; ack = a; d = dv;
    @(posedge clk);
    mv = m_chk ? diff_vec(m_func, m_shad) : '0;
    if (mv != '0 && (!m_err || a)) begin
      m_err = 1'b1; m_idx = low_idx(mv);
    end else if (a) begin
      m_err = 1'b0; m_idx = '0;
    end
    if (c) m_func = dv;
    if (s) m_shad = dv;
    m_chk = s;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, d, tag);
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [NW-1:0] x;
    void'($urandom(32'd4242));
    #22;
    check_all("R9");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9");

    // clean pair
    x = 32'hA55A_0FF0;
    step(1, 0, 0, x, "R1");
    step(0, 1, 0, x, "R2");
    step(0, 0, 0, x, "R3");

    // shadow sees a flipped bit in stage 2: flag one cycle after shadow edge
    step(1, 0, 0, x, "R1");
    step(0, 1, 0, x ^ (32'h1 << 20), "R4");
    check("R4", "no flag at shadow edge", err, 0);
    step(0, 0, 0, x, "R4");
    check("R4", "flag one cycle later", err, 1);
    check("R8", "stage", idx, 2);
    idle(3, "R6");

    // later mismatch in stage 0 does not move index
    step(1, 0, 0, x, "R8");
    step(0, 1, 0, x ^ 32'h1, "R8");
    step(0, 0, 0, x, "R8");
    check("R8", "frozen stage", idx, 2);
    step(0, 1, 1, x, "R1");
    check("R1", "data untouched", q, x);

    // ack clears
    step(0, 0, 1, x, "R7");
    check("R7", "cleared", err, 0);

    // glitch at functional instant, stages 1 and 3
    step(1, 0, 0, x ^ 32'h8000_0100, "R5");
    step(0, 1, 0, x, "R5");
    step(0, 0, 0, x, "R5");
    check("R5", "functional glitch", err, 1);
    check("R8", "lowest of 1,3", idx, 1);

    // ack meets new mismatch in stage 3
    step(1, 0, 0, x, "R7");
    step(0, 1, 0, x ^ 32'h4000_0000, "R7");
    step(0, 0, 1, x, "R7");
    check("R7", "new report wins", idx, 3);
    step(0, 0, 1, x, "R7");

    // same-edge capture of both copies
    step(1, 1, 0, ~x, "R10");
    step(0, 0, 0, x, "R10");
    check("R10", "no flag", err, 0);

    // shadow glitch, stage 0, multi-bit
    step(1, 0, 0, x, "R3");
    step(0, 1, 0, x ^ 32'h81, "R3");
    step(0, 0, 0, x, "R3");
    check("R3", "multi-bit", idx, 0);
    step(0, 0, 1, x, "R7");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [NW-1:0] rv;
      logic c, s, a;
      rv = ($urandom % 3 == 0) ? $urandom : (d ^ (($urandom % 4 == 0) ? (32'h1 << ($urandom % NW)) : '0));
      c = ($urandom % 3 == 0);
      s = ($urandom % 3 == 0);
      a = ($urandom % 5 == 0);
      step(c, s, a, rv, "R3");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule